// File: doc/BRIEF.md
# Packed Vector Lane Blend, Insert and Extract Unit

This unit rearranges lanes of 128-bit vector operands for a SIMD execution pipe. An operation code picks one of four functions and a size code picks the lane width (8, 16, 32 or 64 bits). Two blend functions build a result by choosing, lane by lane, between two source vectors. The choice comes either from an 8-bit immediate mask or from the top bit of each lane of a third vector. Extract copies one lane of the first source, chosen by the immediate, to a 64-bit scalar output with zero fill. Insert writes the low bits of a 64-bit scalar into one lane of the first source and keeps every other lane.

Floating-point lanes are handled as 32-bit or 64-bit integer lanes, because only bits are moved. Each accepted request produces one result one clock later. A small controller with two states, `ST_IDLE` (no result this cycle) and `ST_RESULT` (result valid this cycle), drives `out_valid`. The controller has two transitions. `GO_RESULT` is taken on any edge where `in_valid` is high. `GO_IDLE` is taken on any edge where `in_valid` is low. Reset forces `ST_IDLE`.

Top module: `vlane_unit`

## Requirements
- R1: With `op`=0 (immediate blend), result lane k is taken from `src_b` when `imm[k]` is 1 and from `src_a` when it is 0. This applies for `size`=1 (16-bit, 8 lanes, mask bits 7:0), `size`=2 (32-bit, 4 lanes, bits 3:0) and `size`=3 (64-bit, 2 lanes, bits 1:0). Mask bits above the lane count have no effect. Lane k occupies bits [k*W+W-1 : k*W].
- R2: With `op`=1 (variable blend), result lane k is taken from `src_b` when the top bit of lane k of `src_c` is 1, and from `src_a` otherwise. This applies for `size`=0 (8-bit), `size`=2 and `size`=3.
- R3: With `op`=2 (extract), `scalar_out` holds lane (`imm` mod lane count) of `src_a`, zero-extended to 64 bits. The lane counts are 16, 8, 4 and 2 for `size` 0 to 3. `vec_out` returns `src_a`.
- R4: With `op`=3 (insert), `vec_out` equals `src_a` with lane (`imm` mod lane count) replaced by the low lane-width bits of `scalar_in`. Insert is valid at every size.
- R5: A request sampled with `in_valid` high yields `out_valid` high with its results exactly one clock later. Synchronous active-high `rst` clears `out_valid`, `vec_out`, `scalar_out` and `err`.
- R6: Immediate blend at `size`=0 and variable blend at `size`=1 are unsupported. Each returns `src_a` on `vec_out` and zero on `scalar_out`, with `err` high alongside `out_valid`. Supported requests return `err` low.
- R7: `scalar_out` is zero for every function except extract.
- R8: While `in_valid` is low, `vec_out`, `scalar_out` and `err` keep their last values and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | Function: 0 immediate blend, 1 variable blend, 2 extract, 3 insert |
| size | input | 2 | Lane width: 0 8-bit, 1 16-bit, 2 32-bit, 3 64-bit |
| imm | input | 8 | Blend mask or lane index |
| src_a | input | VEC_W | First source vector |
| src_b | input | VEC_W | Second source vector (blend) |
| src_c | input | VEC_W | Selector vector (variable blend) |
| scalar_in | input | SCALAR_W | Scalar for insert |
| out_valid | output | 1 | Result valid, one clock after request |
| vec_out | output | VEC_W | Vector result |
| scalar_out | output | SCALAR_W | Extracted lane, zero-extended |
| err | output | 1 | Unsupported function and size pair |

## Verification
The bench builds the unit with its defaults, VEC_W of 128 and SCALAR_W of 64. With these values all four lane counts (16, 8, 4 and 2) are reachable, so index wrap-around can be driven at every size with the same immediate. A 64-bit scalar equals the widest lane, so both full-width insert or extract and the zero fill of narrow lanes can be checked. The reference model in the bench loops over lanes bit by bit, whereas the design steers whole bytes.

// File: rtl/vlane_pkg.sv
package vlane_pkg;

    typedef enum logic [1:0] {
        OP_BLEND_IMM = 2'd0,
        OP_BLEND_VAR = 2'd1,
        OP_EXTRACT   = 2'd2,
        OP_INSERT    = 2'd3
    } vl_op_e;

    typedef enum logic [1:0] {
        SZ_B8  = 2'd0,
        SZ_W16 = 2'd1,
        SZ_D32 = 2'd2,
        SZ_Q64 = 2'd3
    } vl_size_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } vl_state_e;

    function automatic logic vl_supported(input vl_op_e f, input vl_size_e s);
        logic ok;
        unique case (f)
            OP_BLEND_IMM: ok = (s != SZ_B8);
            OP_BLEND_VAR: ok = (s != SZ_W16);
            default:      ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/vlane_blend.sv
module vlane_blend
    import vlane_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  vl_size_e           size,
    input  logic               use_var,
    input  logic [7:0]         imm,
    input  logic [VEC_W-1:0]   a,
    input  logic [VEC_W-1:0]   b,
    input  logic [VEC_W-1:0]   c,
    output logic [VEC_W-1:0]   y
);
    localparam int NB = VEC_W / 8;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        logic pick_b;
        always_comb begin
            pick_b = 1'b0;
            if (use_var) begin
                case (size)
                    SZ_B8:   pick_b = c[8*i + 7];
                    SZ_D32:  pick_b = c[32*(i/4) + 31];
                    SZ_Q64:  pick_b = c[64*(i/8) + 63];
                    default: pick_b = 1'b0;
                endcase
            end else begin
                case (size)
                    SZ_W16:  pick_b = imm[(i/2) % 8];
                    SZ_D32:  pick_b = imm[(i/4) % 8];
                    SZ_Q64:  pick_b = imm[(i/8) % 8];
                    default: pick_b = 1'b0;
                endcase
            end
        end
        assign y[8*i +: 8] = pick_b ? b[8*i +: 8] : a[8*i +: 8];
    end

endmodule

// File: rtl/vlane_extract.sv
module vlane_extract
    import vlane_pkg::*;
#(
    parameter int VEC_W    = 128,
    parameter int SCALAR_W = 64
) (
    input  vl_size_e              size,
    input  logic [7:0]            imm,
    input  logic [VEC_W-1:0]      a,
    output logic [SCALAR_W-1:0]   y
);
    logic [VEC_W-1:0]    shifted;
    logic [SCALAR_W-1:0] keep;
    int                  lw;
    int                  lanes;
    int                  idx;

    always_comb begin
        lw      = 8 << int'(size);
        lanes   = VEC_W / lw;
        idx     = int'(imm) % lanes;
        shifted = a >> (idx * lw);
        keep    = {SCALAR_W{1'b1}} >> (SCALAR_W - lw);
        y       = shifted[SCALAR_W-1:0] & keep;
    end

endmodule

// File: rtl/vlane_insert.sv
module vlane_insert
    import vlane_pkg::*;
#(
    parameter int VEC_W    = 128,
    parameter int SCALAR_W = 64
) (
    input  vl_size_e              size,
    input  logic [7:0]            imm,
    input  logic [VEC_W-1:0]      a,
    input  logic [SCALAR_W-1:0]   scalar_in,
    output logic [VEC_W-1:0]      y
);
    localparam int NB = VEC_W / 8;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        logic [SCALAR_W-1:0] piece;
        logic                hit;
        int                  bpl;
        int                  lanes;
        int                  idx;
        always_comb begin
            bpl   = 1 << int'(size);
            lanes = NB / bpl;
            idx   = int'(imm) % lanes;
            hit   = ((i / bpl) == idx);
            piece = scalar_in >> (8 * (i % bpl));
        end
        assign y[8*i +: 8] = hit ? piece[7:0] : a[8*i +: 8];
    end

endmodule

// File: rtl/vlane_unit.sv
module vlane_unit
    import vlane_pkg::*;
#(
    parameter int VEC_W    = 128,
    parameter int SCALAR_W = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [1:0]            op,
    input  logic [1:0]            size,
    input  logic [7:0]            imm,
    input  logic [VEC_W-1:0]      src_a,
    input  logic [VEC_W-1:0]      src_b,
    input  logic [VEC_W-1:0]      src_c,
    input  logic [SCALAR_W-1:0]   scalar_in,
    output logic                  out_valid,
    output logic [VEC_W-1:0]      vec_out,
    output logic [SCALAR_W-1:0]   scalar_out,
    output logic                  err
);
    vl_op_e    fn;
    vl_size_e  sz;
    vl_state_e state;

    logic [VEC_W-1:0]    blend_y;
    logic [VEC_W-1:0]    ins_y;
    logic [SCALAR_W-1:0] ext_y;
    logic [VEC_W-1:0]    nxt_vec;
    logic [SCALAR_W-1:0] nxt_scal;
    logic                nxt_err;

    assign fn = vl_op_e'(op);
    assign sz = vl_size_e'(size);

    vlane_blend #(.VEC_W(VEC_W)) u_blend (
        .size(sz), .use_var(fn == OP_BLEND_VAR), .imm(imm),
        .a(src_a), .b(src_b), .c(src_c), .y(blend_y)
    );

    vlane_extract #(.VEC_W(VEC_W), .SCALAR_W(SCALAR_W)) u_extract (
        .size(sz), .imm(imm), .a(src_a), .y(ext_y)
    );

    vlane_insert #(.VEC_W(VEC_W), .SCALAR_W(SCALAR_W)) u_insert (
        .size(sz), .imm(imm), .a(src_a), .scalar_in(scalar_in), .y(ins_y)
    );

    always_comb begin
        nxt_vec  = src_a;
        nxt_scal = '0;
        nxt_err  = 1'b0;
        if (!vl_supported(fn, sz)) begin
            nxt_err = 1'b1;
        end else begin
            unique case (fn)
                OP_BLEND_IMM,
                OP_BLEND_VAR: nxt_vec  = blend_y;
                OP_EXTRACT:   nxt_scal = ext_y;
                OP_INSERT:    nxt_vec  = ins_y;
            endcase
        end
    end

    // State register: GO_RESULT on an accepted request, GO_IDLE otherwise.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   state <= in_valid ? ST_RESULT : ST_IDLE;
                ST_RESULT: state <= in_valid ? ST_RESULT : ST_IDLE;
            endcase
        end
    end

    // Output process: results load only with an accepted request.
    always_ff @(posedge clk) begin
        if (rst) begin
            vec_out    <= '0;
            scalar_out <= '0;
            err        <= 1'b0;
        end else if (in_valid) begin
            vec_out    <= nxt_vec;
            scalar_out <= nxt_scal;
            err        <= nxt_err;
        end
    end

    assign out_valid = (state == ST_RESULT);

endmodule

// File: rtl/vlane_unit_chk.sv
module vlane_unit_chk
    import vlane_pkg::*;
#(
    parameter int VEC_W    = 128,
    parameter int SCALAR_W = 64
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic [1:0]            op,
    input logic [1:0]            size,
    input logic [VEC_W-1:0]      src_a,
    input logic [VEC_W-1:0]      src_b,
    input logic                  out_valid,
    input logic [VEC_W-1:0]      vec_out,
    input logic [SCALAR_W-1:0]   scalar_out,
    input logic                  err
);
    logic req_ok;
    assign req_ok = vl_supported(vl_op_e'(op), vl_size_e'(size));

    p_reset_clears_r5: assert property (@(posedge clk)
        rst |=> !out_valid);

    p_valid_rise_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_drop_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(vec_out) && $stable(scalar_out) && $stable(err)));

    p_bad_pair_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !req_ok) |=> (err && vec_out == $past(src_a) && scalar_out == '0));

    p_insert_clean_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'd3) |=> !err);

    p_blend_sources_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && req_ok && (op == 2'd0 || op == 2'd1)) |=>
        (((vec_out ^ $past(src_a)) & ~($past(src_a) ^ $past(src_b))) == '0));

    p_byte_zext_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'd2 && size == 2'd0) |=> (scalar_out[SCALAR_W-1:8] == '0));

    p_scalar_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op != 2'd2) |=> (scalar_out == '0));

endmodule

bind vlane_unit vlane_unit_chk #(.VEC_W(VEC_W), .SCALAR_W(SCALAR_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .size(size),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .vec_out(vec_out),
    .scalar_out(scalar_out), .err(err)
);

// File: tb/test_vlane_unit.sv
module test_vlane_unit;
    localparam int VW = 128;
    localparam int SW = 64;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [1:0]    op;
    logic [1:0]    size;
    logic [7:0]    imm;
    logic [VW-1:0] src_a, src_b, src_c;
    logic [SW-1:0] scalar_in;
    logic          out_valid;
    logic [VW-1:0] vec_out;
    logic [SW-1:0] scalar_out;
    logic          err;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    vlane_unit #(.VEC_W(VW), .SCALAR_W(SW)) i_vlane_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .size(size),
        .imm(imm), .src_a(src_a), .src_b(src_b), .src_c(src_c),
        .scalar_in(scalar_in), .out_valid(out_valid), .vec_out(vec_out),
        .scalar_out(scalar_out), .err(err)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R5 watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    // Independent lane-by-lane model of the requirements.
    task automatic model(input logic [1:0] f, input logic [1:0] s, input logic [7:0] m,
                         input logic [VW-1:0] a, input logic [VW-1:0] b,
                         input logic [VW-1:0] c, input logic [SW-1:0] sc,
                         output logic [VW-1:0] ev, output logic [SW-1:0] es,
                         output logic ee);
        int w;
        int n;
        int idx;
        logic sel;
        w  = 8 << s;
        n  = VW / w;
        ev = a;
        es = '0;
        ee = 1'b0;
        if ((f == 2'd0 && s == 2'd0) || (f == 2'd1 && s == 2'd1)) begin
            ee = 1'b1;
        end else if (f == 2'd0 || f == 2'd1) begin
            for (int k = 0; k < n; k++) begin
                sel = (f == 2'd0) ? m[k] : c[k*w + w - 1];
                for (int j = 0; j < w; j++) ev[k*w + j] = sel ? b[k*w + j] : a[k*w + j];
            end
        end else if (f == 2'd2) begin
            idx = int'(m) % n;
            for (int j = 0; j < w; j++) es[j] = a[idx*w + j];
        end else begin
            idx = int'(m) % n;
            for (int j = 0; j < w; j++) ev[idx*w + j] = sc[j];
        end
    endtask

    task automatic check_out(input string tag, input logic [VW-1:0] ev,
                             input logic [SW-1:0] es, input logic ee, input logic ov);
        n_checks++;
        if (vec_out !== ev || scalar_out !== es || err !== ee || out_valid !== ov) begin
            n_fails++;
            $display("FAIL %s: actual vec=%h scal=%h err=%b vld=%b expected vec=%h scal=%h err=%b vld=%b",
                     tag, vec_out, scalar_out, err, out_valid, ev, es, ee, ov);
        end
    endtask

    // One request; result checked on the following falling edge.
    task automatic run_op(input string tag, input logic [1:0] f, input logic [1:0] s,
                          input logic [7:0] m, input logic [VW-1:0] a,
                          input logic [VW-1:0] b, input logic [VW-1:0] c,
                          input logic [SW-1:0] sc);
        logic [VW-1:0] ev;
        logic [SW-1:0] es;
        logic          ee;
        @(negedge clk);
        in_valid = 1'b1; op = f; size = s; imm = m;
        src_a = a; src_b = b; src_c = c; scalar_in = sc;
        model(f, s, m, a, b, c, sc, ev, es, ee);
        @(negedge clk);
        in_valid = 1'b0;
        check_out(tag, ev, es, ee, 1'b1);
    endtask

    function automatic logic [VW-1:0] rnd_vec();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; op = '0; size = '0; imm = '0;
        src_a = '0; src_b = '0; src_c = '0; scalar_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_out("R5 reset state", '0, '0, 1'b0, 1'b0);
    endtask

    task automatic t_blend_imm();
        logic [VW-1:0] a = 128'h00112233_44556677_8899AABB_CCDDEEFF;
        logic [VW-1:0] b = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;
        run_op("R1 word blend 0xA5", 2'd0, 2'd1, 8'hA5, a, b, '0, '0);
        run_op("R1 dword blend upper bits ignored", 2'd0, 2'd2, 8'hF6, a, b, '0, '0);
        run_op("R1 qword blend 0x02", 2'd0, 2'd3, 8'h02, a, b, '0, '0);
        run_op("R1 dword blend zero mask", 2'd0, 2'd2, 8'h00, a, b, '0, '0);
        for (int i = 0; i < 6; i++)
            run_op("R1 random blend", 2'd0, 2'(1 + (i % 3)), 8'($urandom), rnd_vec(), rnd_vec(), '0, '0);
    endtask

    task automatic t_blend_var();
        logic [VW-1:0] a = rnd_vec();
        logic [VW-1:0] b = rnd_vec();
        run_op("R2 byte var blend alternating", 2'd1, 2'd0, 8'h00, a, b,
               {8{16'h80_7F}}, '0);
        run_op("R2 dword var blend", 2'd1, 2'd2, 8'hFF, a, b,
               128'h80000000_7FFFFFFF_FFFFFFFF_00000000, '0);
        run_op("R2 qword var blend", 2'd1, 2'd3, 8'h00, a, b,
               128'h7FFFFFFF_FFFFFFFF_80000000_00000000, '0);
        for (int i = 0; i < 6; i++)
            run_op("R2 random var blend", 2'd1, (i % 2 == 0) ? 2'd0 : 2'd2, '0,
                   rnd_vec(), rnd_vec(), rnd_vec(), '0);
    endtask

    task automatic t_extract();
        logic [VW-1:0] a = 128'hFEDCBA98_76543210_0F1E2D3C_4B5A6978;
        for (int s = 0; s < 4; s++) begin
            run_op("R3 extract lane 1", 2'd2, 2'(s), 8'd1, a, rnd_vec(), '0, '0);
            run_op("R3 extract index wraps", 2'd2, 2'(s), 8'd17, a, rnd_vec(), '0, '0);
        end
        run_op("R3 extract top byte lane", 2'd2, 2'd0, 8'd15, a, '0, '0, '0);
        run_op("R3 extract high qword", 2'd2, 2'd3, 8'hFF, a, '0, '0, '0);
    endtask

    task automatic t_insert();
        logic [SW-1:0] sc = 64'hA1B2C3D4_E5F60718;
        for (int s = 0; s < 4; s++) begin
            run_op("R4 insert lane 0", 2'd3, 2'(s), 8'd0, rnd_vec(), rnd_vec(), '0, sc);
            run_op("R4 insert index wraps", 2'd3, 2'(s), 8'd203, rnd_vec(), rnd_vec(), '0, sc);
        end
    endtask

    task automatic t_error();
        run_op("R6 immediate blend at byte size", 2'd0, 2'd0, 8'hFF, rnd_vec(), rnd_vec(), '0, '1);
        run_op("R6 variable blend at word size", 2'd1, 2'd1, 8'h00, rnd_vec(), rnd_vec(), '1, '1);
        run_op("R6 R7 supported clears err", 2'd3, 2'd2, 8'd2, rnd_vec(), '0, '0, 64'h55);
    endtask

    task automatic t_hold();
        logic [VW-1:0] ev;
        logic [SW-1:0] es;
        logic          ee;
        logic [VW-1:0] a = rnd_vec();
        run_op("R3 extract before idle", 2'd2, 2'd2, 8'd3, a, '0, '0, '0);
        model(2'd2, 2'd2, 8'd3, a, '0, '0, '0, ev, es, ee);
        @(negedge clk);
        op = 2'd3; size = 2'd0; imm = 8'd5; src_a = rnd_vec(); scalar_in = '1;
        @(negedge clk);
        @(negedge clk);
        check_out("R8 idle inputs ignored", ev, es, ee, 1'b0);
    endtask

    task automatic t_back_to_back();
        logic [VW-1:0] e1, e2;
        logic [SW-1:0] s1, s2;
        logic          r1, r2;
        logic [VW-1:0] a1 = rnd_vec();
        logic [VW-1:0] a2 = rnd_vec();
        model(2'd3, 2'd1, 8'd6, a1, '0, '0, 64'h1234, e1, s1, r1);
        model(2'd2, 2'd1, 8'd6, a2, '0, '0, '0, e2, s2, r2);
        @(negedge clk);
        in_valid = 1'b1; op = 2'd3; size = 2'd1; imm = 8'd6; src_a = a1; scalar_in = 64'h1234;
        @(negedge clk);
        op = 2'd2; src_a = a2; scalar_in = '0;
        check_out("R5 first of back-to-back", e1, s1, r1, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        check_out("R5 second of back-to-back", e2, s2, r2, 1'b1);
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_fails++;
            $display("FAIL R5 valid drop: actual=%b expected=0", out_valid);
        end
    endtask

    task automatic t_mid_reset();
        @(negedge clk);
        in_valid = 1'b1; op = 2'd0; size = 2'd3; imm = 8'd1; src_a = rnd_vec(); src_b = rnd_vec();
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_out("R5 reset after result", '0, '0, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_blend_imm();
        t_blend_var();
        t_extract();
        t_insert();
        t_error();
        t_hold();
        t_back_to_back();
        t_mid_reset();
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule